// File: doc/BRIEF.md
# Pixel Brightness, Contrast and Saturation Adjuster

This stage corrects colour one pixel at a time, ahead of a colour-space converter. Each valid cycle it takes one unsigned luma sample and two chroma samples, which arrive already signed and centred on zero. Luma is scaled by a contrast gain and then shifted by a brightness offset. The chroma pair is turned through a programmable sine/cosine rotation, which sets both saturation (the cosine magnitude) and hue (the sine term). Every result is rounded to nearest and saturated to its output range. The outputs appear a fixed two cycles after the inputs, and the valid flag travels with them.

Two packed configuration words are loaded through a simple write port into a shadow set. The shadow set moves into the active set only on a frame-boundary strobe, so software can stage a new setting at any moment without tearing the frame being drawn. The pass-through setting reproduces the input exactly. A contrast of about 255/219 with a brightness of -19 and a cosine of about 128/112 stretches limited-range YCbCr to full range for a converter that expects full-range input.

Top module: `pix_bcs_adjust`

## Requirements
- R1: While reset is low and right after it, out_valid is 0 and out_y, out_cb and out_cr are 0. Both the active and the shadow settings come up as pass-through: contrast 64, brightness 0, sine 0, cosine 128.
- R2: With the pass-through setting active, every accepted pixel leaves unchanged. out_y equals in_y, out_cb equals in_cb and out_cr equals in_cr.
- R3: A pixel accepted with in_valid high in cycle n appears with out_valid high in cycle n+2. out_valid is low in cycle n+2 whenever in_valid was low in cycle n.
- R4: Luma is computed as ((in_y * C + 32) >> 6) + B. C is the unsigned 3.6 contrast in word 0 bits 26:18, and B is the two's-complement brightness in word 0 bits 7:0. The gain is applied before the offset.
- R5: The luma result is saturated to 0..255.
- R6: Chroma is computed as Cb' = floor((Cb*K + Cr*S + 64) / 128) and Cr' = floor((Cr*K - Cb*S + 64) / 128). S is the signed 4.7 sine in word 1 bits 26:16, and K is the unsigned 3.7 cosine in word 1 bits 9:0.
- R7: Each chroma result is saturated to -128..127.
- R8: A write with cfg_we high loads word 0 into the shadow set when cfg_sel is 0, and word 1 when cfg_sel is 1. The other word stays as it was. No write changes the active setting or any pixel until frame_strobe is pulsed.
- R9: A pixel accepted in the same cycle as frame_strobe is still processed with the old active setting. Pixels from the next cycle on use the shadow contents as they stood before that edge, so a write made in the strobe cycle waits for the following strobe.
- R10: Back-to-back pixels and bubbles keep their order, one result per accepted pixel. While out_valid is low, out_y, out_cb and out_cr hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe into the shadow setting |
| cfg_sel | input | 1 | 0 selects word 0 (contrast/brightness), 1 selects word 1 (sine/cosine) |
| cfg_wdata | input | 32 | Packed configuration word |
| frame_strobe | input | 1 | Frame-boundary pulse that copies shadow to active |
| in_valid | input | 1 | Input pixel valid |
| in_y | input | 8 | Unsigned luma in |
| in_cb | input | 8 | Signed blue-difference chroma in |
| in_cr | input | 8 | Signed red-difference chroma in |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Adjusted luma |
| out_cb | output | 8 | Adjusted signed blue-difference chroma |
| out_cr | output | 8 | Adjusted signed red-difference chroma |

## Verification
The assertions watch several properties on every cycle. They check the two-cycle link between in_valid and out_valid and that the data outputs hold during bubbles. They check that the active setting moves only on a strobe and then takes exactly the earlier shadow contents, and that a pixel accepted under the pass-through setting comes out unchanged. The arithmetic needs the bench's directed scenarios: the rounding and saturation corners of the limited-to-full expansion, the hue rotation for both signs of the sine, and the field positions in the two words. So does the exact cycle where a strobe splits old and new settings, including a write made in the strobe cycle.

// File: rtl/pix_bcs_pkg.sv
package pix_bcs_pkg;

    // Register field geometry: a downstream programming model decodes these.
    localparam int CFG_W     = 32;
    localparam int CON_W     = 9;   // unsigned 3.6
    localparam int CON_FRAC  = 6;
    localparam int CON_LSB   = 18;
    localparam int BRI_W     = 8;   // two's complement integer
    localparam int SIN_W     = 11;  // signed 4.7
    localparam int SIN_LSB   = 16;
    localparam int COS_W     = 10;  // unsigned 3.7
    localparam int TRIG_FRAC = 7;

    typedef struct packed {
        logic        [CON_W-1:0] contrast;
        logic signed [BRI_W-1:0] brightness;
        logic signed [SIN_W-1:0] sine;
        logic        [COS_W-1:0] cosine;
    } bcs_cfg_t;

    localparam bcs_cfg_t CFG_PASS = '{
        contrast:   CON_W'(1 << CON_FRAC),
        brightness: '0,
        sine:       '0,
        cosine:     COS_W'(1 << TRIG_FRAC)
    };

endpackage

// File: rtl/bcs_cfg_bank.sv
module bcs_cfg_bank
    import pix_bcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic                 commit,
    output bcs_cfg_t             shd_cfg,
    output bcs_cfg_t             act_cfg
);

    typedef struct packed {
        bcs_cfg_t shd;
        bcs_cfg_t act;
    } bank_t;

    bank_t st_d, st_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[CFG_W-1:CON_LSB+CON_W], wr_data[SIN_LSB-1:COS_W]};

    always_comb begin
        st_d = st_q;
        // Commit samples the shadow before this cycle's write lands.
        if (commit) begin
            st_d.act = st_q.shd;
        end
        if (wr_en) begin
            if (!wr_sel) begin
                st_d.shd.contrast   = wr_data[CON_LSB +: CON_W];
                st_d.shd.brightness = $signed(wr_data[BRI_W-1:0]);
            end else begin
                st_d.shd.sine       = $signed(wr_data[SIN_LSB +: SIN_W]);
                st_d.shd.cosine     = wr_data[COS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shd <= CFG_PASS;
            st_q.act <= CFG_PASS;
        end else begin
            st_q <= st_d;
        end
    end

    assign shd_cfg = st_q.shd;
    assign act_cfg = st_q.act;

endmodule

// File: rtl/bcs_luma_lane.sv
module bcs_luma_lane
    import pix_bcs_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_s1,
    input  logic                    load_s2,
    input  logic [PIX_W-1:0]        y_in,
    input  logic [CON_W-1:0]        contrast,
    input  logic signed [BRI_W-1:0] brightness,
    output logic [PIX_W-1:0]        y_out
);

    localparam int PROD_W = PIX_W + CON_W;
    localparam int RND_W  = PROD_W + 1 - CON_FRAC;
    localparam int SUM_W  = RND_W + 2;
    localparam logic [PROD_W:0]         HALF   = (PROD_W+1)'(1 << (CON_FRAC - 1));
    localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'((1 << PIX_W) - 1);

    typedef struct packed {
        logic [PROD_W-1:0]       prod;
        logic signed [BRI_W-1:0] bri;
        logic [PIX_W-1:0]        y;
    } lane_t;

    lane_t st_d, st_q;
    logic [PROD_W:0]         biased;
    logic [RND_W-1:0]        rounded;
    logic signed [SUM_W-1:0] total;

    always_comb begin
        st_d    = st_q;
        biased  = {1'b0, st_q.prod} + HALF;
        rounded = RND_W'(biased >> CON_FRAC);
        total   = $signed(SUM_W'(rounded)) + SUM_W'(st_q.bri);
        // Stage 1: gain; the offset travels with its pixel.
        if (load_s1) begin
            st_d.prod = PROD_W'(y_in) * PROD_W'(contrast);
            st_d.bri  = brightness;
        end
        // Stage 2: round, offset, saturate.
        if (load_s2) begin
            if (total < 0) begin
                st_d.y = '0;
            end else if (total > LIM_HI) begin
                st_d.y = '1;
            end else begin
                st_d.y = total[PIX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out = st_q.y;

endmodule

// File: rtl/bcs_chroma_lane.sv
module bcs_chroma_lane
    import pix_bcs_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter bit NEG_CROSS = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_s1,
    input  logic                    load_s2,
    input  logic signed [PIX_W-1:0] a_in,
    input  logic signed [PIX_W-1:0] b_in,
    input  logic signed [SIN_W-1:0] sine,
    input  logic [COS_W-1:0]        cosine,
    output logic signed [PIX_W-1:0] c_out
);

    localparam int TRIG_W = SIN_W;
    localparam int PRD_W  = PIX_W + TRIG_W;
    localparam int ACC_W  = PRD_W + 1;
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1 << (TRIG_FRAC - 1));
    localparam logic signed [ACC_W-1:0] LIM_HI = ACC_W'((1 << (PIX_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LIM_LO = -ACC_W'(1 << (PIX_W - 1));

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [PIX_W-1:0] c;
    } lane_t;

    lane_t st_d, st_q;
    logic signed [TRIG_W-1:0] cos_s;
    logic signed [PRD_W-1:0]  p_main;
    logic signed [PRD_W-1:0]  p_cross;
    logic signed [ACC_W-1:0]  shifted;

    always_comb begin
        st_d    = st_q;
        cos_s   = $signed(TRIG_W'(cosine));
        p_main  = PRD_W'(a_in) * PRD_W'(cos_s);
        p_cross = PRD_W'(b_in) * PRD_W'(sine);
        shifted = (st_q.acc + HALF) >>> TRIG_FRAC;
        // Stage 1: rotation sum at full precision.
        if (load_s1) begin
            if (NEG_CROSS) begin
                st_d.acc = ACC_W'(p_main) - ACC_W'(p_cross);
            end else begin
                st_d.acc = ACC_W'(p_main) + ACC_W'(p_cross);
            end
        end
        // Stage 2: round to nearest, saturate.
        if (load_s2) begin
            if (shifted > LIM_HI) begin
                st_d.c = LIM_HI[PIX_W-1:0];
            end else if (shifted < LIM_LO) begin
                st_d.c = LIM_LO[PIX_W-1:0];
            end else begin
                st_d.c = shifted[PIX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign c_out = st_q.c;

endmodule

// File: rtl/pix_bcs_adjust.sv
module pix_bcs_adjust
    import pix_bcs_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             frame_strobe,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_y,
    input  logic [PIX_W-1:0] in_cb,
    input  logic [PIX_W-1:0] in_cr,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_cb,
    output logic [PIX_W-1:0] out_cr
);

    localparam int N_CHROMA = 2;

    typedef struct packed {
        logic v1;
        logic v2;
    } vpipe_t;

    vpipe_t   vp_d, vp_q;
    bcs_cfg_t shd_cfg;
    bcs_cfg_t act_cfg;

    logic signed [PIX_W-1:0] ch_in  [N_CHROMA];
    logic signed [PIX_W-1:0] ch_out [N_CHROMA];

    bcs_cfg_bank u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .commit  (frame_strobe),
        .shd_cfg (shd_cfg),
        .act_cfg (act_cfg)
    );

    always_comb begin
        vp_d    = vp_q;
        vp_d.v1 = in_valid;
        vp_d.v2 = vp_q.v1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp_q <= '0;
        end else begin
            vp_q <= vp_d;
        end
    end

    bcs_luma_lane #(.PIX_W(PIX_W)) u_luma (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_s1    (in_valid),
        .load_s2    (vp_q.v1),
        .y_in       (in_y),
        .contrast   (act_cfg.contrast),
        .brightness (act_cfg.brightness),
        .y_out      (out_y)
    );

    assign ch_in[0] = $signed(in_cb);
    assign ch_in[1] = $signed(in_cr);

    // Lane 0 yields Cb (cross term added), lane 1 yields Cr (cross term subtracted).
    for (genvar g = 0; g < N_CHROMA; g++) begin : g_chroma
        bcs_chroma_lane #(
            .PIX_W     (PIX_W),
            .NEG_CROSS (g == 1)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_s1 (in_valid),
            .load_s2 (vp_q.v1),
            .a_in    (ch_in[g]),
            .b_in    (ch_in[N_CHROMA-1-g]),
            .sine    (act_cfg.sine),
            .cosine  (act_cfg.cosine),
            .c_out   (ch_out[g])
        );
    end

    assign out_valid = vp_q.v2;
    assign out_cb    = ch_out[0];
    assign out_cr    = ch_out[1];

endmodule

// File: rtl/pix_bcs_adjust_chk.sv
module pix_bcs_adjust_chk
    import pix_bcs_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_strobe,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_y,
    input logic [PIX_W-1:0] in_cb,
    input logic [PIX_W-1:0] in_cr,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_y,
    input logic [PIX_W-1:0] out_cb,
    input logic [PIX_W-1:0] out_cr,
    input bcs_cfg_t         shd_cfg,
    input bcs_cfg_t         act_cfg
);

    a_r3_valid_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r3_idle_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    a_r10_hold_in_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable({out_y, out_cb, out_cr}));

    a_r8_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(act_cfg));

    a_r9_commit_takes_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> (act_cfg == $past(shd_cfg)));

    a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && act_cfg == CFG_PASS) |-> ##2
        (out_y == $past(in_y, 2) && out_cb == $past(in_cb, 2) && out_cr == $past(in_cr, 2)));

endmodule

bind pix_bcs_adjust pix_bcs_adjust_chk #(.PIX_W(PIX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .in_valid     (in_valid),
    .in_y         (in_y),
    .in_cb        (in_cb),
    .in_cr        (in_cr),
    .out_valid    (out_valid),
    .out_y        (out_y),
    .out_cb       (out_cb),
    .out_cr       (out_cr),
    .shd_cfg      (shd_cfg),
    .act_cfg      (act_cfg)
);

// File: tb/pix_bcs_adjust_bench.sv
module pix_bcs_adjust_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic       frame_strobe = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_y = '0;
    logic [7:0] in_cb = '0;
    logic [7:0] in_cr = '0;
    logic       out_valid;
    logic [7:0] out_y;
    logic [7:0] out_cb;
    logic [7:0] out_cr;

    int n_chk  = 0;
    int n_fail = 0;

    // Expected active and shadow settings.
    int a_con = 64, a_bri = 0, a_sin = 0, a_cos = 128;
    int s_con = 64, s_bri = 0, s_sin = 0, s_cos = 128;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_bcs_adjust u_pix_bcs_adjust (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
        .cfg_wdata (cfg_wdata), .frame_strobe (frame_strobe), .in_valid (in_valid),
        .in_y (in_y), .in_cb (in_cb), .in_cr (in_cr), .out_valid (out_valid),
        .out_y (out_y), .out_cb (out_cb), .out_cr (out_cr)
    );

    function automatic int ref_y(int y, int c, int b);
        int r;
        r = ((y * c + 32) >>> 6) + b;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    function automatic int ref_c(int a, int b, int k, int s, bit neg);
        int acc;
        acc = neg ? (a * k - b * s) : (a * k + b * s);
        acc = (acc + 64) >>> 7;
        if (acc > 127) acc = 127;
        if (acc < -128) acc = -128;
        return acc;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(bit sel, logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_shadow(int con, int bri, int sn, int cs);
        wr_cfg(1'b0, (32'(con) << 18) | (32'(bri) & 32'hFF));
        wr_cfg(1'b1, ((32'(sn) & 32'h7FF) << 16) | 32'(cs));
        s_con = con; s_bri = bri; s_sin = sn; s_cos = cs;
    endtask

    task automatic commit();
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        a_con = s_con; a_bri = s_bri; a_sin = s_sin; a_cos = s_cos;
    endtask

    // One isolated pixel, checked two cycles later against the expected active setting.
    task automatic pix(string req, int y, int cb, int cr);
        in_valid = 1'b1; in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " y"},  int'(out_y), ref_y(y, a_con, a_bri));
        chk({req, " cb"}, int'($signed(out_cb)), ref_c(cb, cr, a_cos, a_sin, 1'b0));
        chk({req, " cr"}, int'($signed(out_cr)), ref_c(cr, cb, a_cos, a_sin, 1'b1));
    endtask

    task automatic t_reset();
        chk("R1 valid in reset", int'(out_valid), 0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 y", int'(out_y), 0);
        chk("R1 cb", int'(out_cb), 0);
        chk("R1 cr", int'(out_cr), 0);
        pix("R1 pass-through after reset", 77, -33, 90);
    endtask

    task automatic t_pass();
        pix("R2 zero", 0, 0, 0);
        pix("R2 max", 255, 127, -128);
        pix("R2 mid", 128, -128, 127);
        pix("R2 odd", 1, -1, 1);
    endtask

    task automatic t_expand();
        set_shadow(75, -19, 0, 146);
        commit();
        pix("R4 black", 16, 0, 0);
        chk("R4 black literal", int'(out_y), 0);
        pix("R4 mid", 128, 50, -50);
        chk("R4 mid literal", int'(out_y), 131);
        chk("R6 cb scale literal", int'($signed(out_cb)), 57);
        pix("R5 white clamp", 235, 112, -112);
        chk("R5 white literal", int'(out_y), 255);
        chk("R7 cb high clamp", int'($signed(out_cb)), 127);
        chk("R7 cr low clamp", int'($signed(out_cr)), -128);
    endtask

    task automatic t_hue();
        set_shadow(64, 0, 64, 128);
        commit();
        pix("R6 positive sine", 100, 40, 20);
        chk("R6 cb literal", int'($signed(out_cb)), 50);
        chk("R6 cr literal", int'($signed(out_cr)), 0);
        set_shadow(64, 0, -64, 128);
        commit();
        pix("R6 negative sine", 100, 40, 20);
        chk("R6 cr neg literal", int'($signed(out_cr)), 40);
        pix("R6 rounding", 3, -3, 5);
    endtask

    task automatic t_clamp();
        set_shadow(64, -128, 0, 1023);
        commit();
        pix("R5 low clamp", 10, 127, -128);
        chk("R5 low literal", int'(out_y), 0);
        set_shadow(511, 127, 1023, 1023);
        commit();
        pix("R5 high clamp", 255, 127, 127);
        pix("R7 extreme", 0, -128, 127);
    endtask

    task automatic t_shadow();
        set_shadow(64, 0, 0, 128);
        commit();
        set_shadow(128, 10, 0, 64);
        pix("R8 staged not applied", 60, 40, -40);
        chk("R8 y unchanged", int'(out_y), 60);
        commit();
        pix("R8 applied after strobe", 60, 40, -40);
        chk("R8 y new", int'(out_y), 130);
        // Only word 1 rewritten: luma setting must survive.
        wr_cfg(1'b1, 32'd128);
        s_sin = 0; s_cos = 128;
        commit();
        pix("R8 word select", 60, 40, -40);
        chk("R8 luma kept", int'(out_y), 130);
        chk("R8 chroma updated", int'($signed(out_cb)), 40);
    endtask

    task automatic t_boundary();
        set_shadow(64, 0, 0, 128);
        commit();
        set_shadow(128, 0, 0, 128);
        // Pixel, strobe and a new word-0 write in one cycle.
        in_valid = 1'b1; in_y = 8'd50; in_cb = '0; in_cr = '0;
        frame_strobe = 1'b1;
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'(192) << 18;
        @(negedge clk);
        frame_strobe = 1'b0; cfg_we = 1'b0;
        in_y = 8'd50;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 strobe-cycle pixel old", int'(out_y), 50);
        @(negedge clk);
        chk("R9 next pixel new", int'(out_y), 100);
        a_con = 128; s_con = 192;
        commit();
        pix("R9 late write on next strobe", 50, 0, 0);
        chk("R9 literal", int'(out_y), 150);
    endtask

    task automatic t_stream();
        set_shadow(64, 5, 0, 128);
        commit();
        in_valid = 1'b1; in_y = 8'd10; in_cb = 8'd1; in_cr = 8'd2;
        @(negedge clk);
        in_y = 8'd20; in_cb = 8'd3; in_cr = 8'd4;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 first y", int'(out_y), 15);
        chk("R10 first cb", int'(out_cb), 1);
        @(negedge clk);
        in_valid = 1'b1; in_y = 8'd30; in_cb = 8'd5; in_cr = 8'd6;
        chk("R10 second y", int'(out_y), 25);
        chk("R10 second cr", int'(out_cr), 4);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 bubble valid", int'(out_valid), 0);
        chk("R10 bubble hold y", int'(out_y), 25);
        chk("R10 bubble hold cb", int'(out_cb), 3);
        @(negedge clk);
        chk("R10 third valid", int'(out_valid), 1);
        chk("R10 third y", int'(out_y), 35);
        chk("R10 third cr", int'(out_cr), 6);
        @(negedge clk);
        chk("R3 idle after stream", int'(out_valid), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pass();
        t_expand();
        t_hue();
        t_clamp();
        t_shadow();
        t_boundary();
        t_stream();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule